// File: doc/BRIEF.md
# PHY Management Interrupt and Poll-Change Monitor

This block holds the interrupt status and enable state for the management port of an embedded Ethernet PHY. It raises one of three sticky status flags in three cases:
- a host-issued management read or write completes;
- an internally generated management frame completes;
- a periodically polled PHY status word differs from the one polled just before it.

Each flag reaches the active-high interrupt output only while its enable is set. Software clears a flag by writing a 1 to its bit.

The poll monitor keeps a shadow copy of the last polled word. Any change of the poll access-method select empties the shadow and arms a one-shot suppression, so the first poll under the new method only reloads the shadow. Only a hard reset clears the flags and the enables. The soft reset and stop controls leave every bit as it is. The poll input is a valid/ready stream that never applies back-pressure: `poll_ready` is always 1, and a word counts as taken in every cycle where `poll_valid` is 1.

Top module: `phy_mgmt_irq_monitor`

## Requirements
- R1: When a poll word is accepted and differs from the shadow copy (and no suppression applies), status bit 0 (poll change) reads 1 from the next cycle on.
- R2: The first poll word accepted after a hard reset, or after any change of `poll_method` (including a poll in the same cycle as the change), does not set status bit 0. That word is loaded into the shadow, and later polls compare against it.
- R3: A poll word equal to the shadow copy does not set status bit 0. The shadow always holds the most recently accepted word.
- R4: A completion pulse with `op_internal`=0 sets status bit 1 (host complete) only. With `op_internal`=1 it sets status bit 2 (internal complete) only.
- R5: A register write to address 0 (status) clears each status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R6: If a set event and a write-one clear hit the same status bit in the same cycle, the bit ends up 1. A bit that is already set stays 1 under repeated events.
- R7: `irq` is 1 exactly when (status bit 0 AND enable bit 0) OR ((status bit 1 OR status bit 2) AND enable bit 1). It is combinational from the registered bits.
- R8: `hard_rst_n`=0 clears all status bits and both enable bits. `soft_rst` and `stop` change none of them.
- R9: Reads are combinational and allowed at all times. Address 0 returns the status in bits [2:0], address 1 returns the enables in bits [1:0] (write to address 1 loads them), and any other address reads 0. Unused bits read 0. `poll_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Soft reset; no effect on this block's bits |
| stop | input | 1 | Stop control; no effect on this block's bits |
| op_done | input | 1 | One-cycle management operation completion pulse |
| op_internal | input | 1 | Tags the completion: 1 internal, 0 host |
| poll_valid | input | 1 | Polled status word valid |
| poll_ready | output | 1 | Always 1; poll stream is never stalled |
| poll_data | input | POLL_W | Polled PHY status word |
| poll_method | input | 1 | Poll access-method select |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | Active-high interrupt request |

## Verification
The poll compare is tried with repeated equal words, with changing words, with a method switch alone followed by a poll, and with a switch in the same cycle as a poll. Together these tell true change detection apart from the one-shot suppression and from stale shadow contents. Completions are sent with both tags and overlapped with write-one clears of the same and of different bits, which separates tag routing, clear masking and set priority. Enable patterns that gate only one group, together with soft reset and stop pulses followed by a hard reset, show which bits feed the interrupt and which reset reaches them.

// File: rtl/pmi_pkg.sv
package pmi_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd1;
  localparam int NUM_ST    = 3;
  localparam int ST_CHANGE = 0;
  localparam int ST_HOST   = 1;
  localparam int ST_INTL   = 2;
  localparam int NUM_EN    = 2;
  localparam int EN_CHANGE = 0;
  localparam int EN_DONE   = 1;
endpackage

// File: rtl/pmi_poll_shadow.sv
module pmi_poll_shadow #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         poll_valid,
  input  logic [W-1:0] poll_data,
  input  logic         method,
  output logic         change_evt
);
  logic [W-1:0] shadow_q;
  logic         method_q;
  logic         pending_q;
  logic         method_chg;

  assign method_chg = (method != method_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q  <= '0;
      method_q  <= 1'b0;
      pending_q <= 1'b1;
    end else begin
      method_q <= method;
      if (poll_valid) begin
        shadow_q  <= poll_data;
        pending_q <= 1'b0;
      end else if (method_chg) begin
        shadow_q  <= '0;
        pending_q <= 1'b1;
      end
    end
  end

  assign change_evt = poll_valid && !pending_q && !method_chg &&
                      (poll_data != shadow_q);

  // R2: a lone method switch means the next cycle cannot report a change
  assert_switch_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (method_chg && !poll_valid) |=> !change_evt);

  // R3: a word matching the stored copy never reports a change
  assert_equal_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_valid && poll_data == shadow_q) |-> !change_evt);

  // R3: shadow tracks the last accepted word
  assert_shadow_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    poll_valid |=> (shadow_q == $past(poll_data)));
endmodule

// File: rtl/pmi_w1c_bits.sv
module pmi_w1c_bits #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    // R6: a set event always leaves the bit at 1
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);

    // R5: a clear without a set empties the bit
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !q[i]);

    // R5: with neither event the bit holds
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr[i] && !set[i]) |=> (q[i] == $past(q[i])));
  end
endmodule

// File: rtl/pmi_irq_gate.sv
module pmi_irq_gate
  import pmi_pkg::*;
(
  input  logic [NUM_ST-1:0] status,
  input  logic [NUM_EN-1:0] enable,
  output logic              irq
);
  logic change_req;
  logic done_req;

  assign change_req = status[ST_CHANGE] & enable[EN_CHANGE];
  assign done_req   = (status[ST_HOST] | status[ST_INTL]) & enable[EN_DONE];
  assign irq        = change_req | done_req;

  // R7: nothing pending means no request
  always_comb begin
    assert_no_source_R7: assert (!(status == '0 && irq));
  end
endmodule

// File: rtl/phy_mgmt_irq_monitor.sv
module phy_mgmt_irq_monitor
  import pmi_pkg::*;
#(
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              hard_rst_n,
  input  logic              soft_rst,
  input  logic              stop,
  input  logic              op_done,
  input  logic              op_internal,
  input  logic              poll_valid,
  output logic              poll_ready,
  input  logic [POLL_W-1:0] poll_data,
  input  logic              poll_method,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic              change_evt;
  logic [NUM_ST-1:0] st_set;
  logic [NUM_ST-1:0] st_clr;
  logic [NUM_ST-1:0] st_q;
  logic [NUM_EN-1:0] en_q;
  logic              wr_status;
  logic              wr_enable;
  logic              unused_inputs;

  assign poll_ready = 1'b1;
  assign unused_inputs = ^{reg_wdata[DATA_W-1:NUM_ST], soft_rst, stop};

  pmi_poll_shadow #(.W(POLL_W)) u_shadow (
    .clk       (clk),
    .rst_n     (hard_rst_n),
    .poll_valid(poll_valid),
    .poll_data (poll_data),
    .method    (poll_method),
    .change_evt(change_evt)
  );

  assign wr_status = reg_wr && (reg_addr == ADDR_STATUS);
  assign wr_enable = reg_wr && (reg_addr == ADDR_ENABLE);

  always_comb begin
    st_set = '0;
    st_set[ST_CHANGE] = change_evt;
    st_set[ST_HOST]   = op_done && !op_internal;
    st_set[ST_INTL]   = op_done && op_internal;
  end

  assign st_clr = wr_status ? reg_wdata[NUM_ST-1:0] : '0;

  pmi_w1c_bits #(.N(NUM_ST)) u_status (
    .clk  (clk),
    .rst_n(hard_rst_n),
    .set  (st_set),
    .clr  (st_clr),
    .q    (st_q)
  );

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n)    en_q <= '0;
    else if (wr_enable) en_q <= reg_wdata[NUM_EN-1:0];
  end

  always_comb begin
    case (reg_addr)
      ADDR_STATUS: reg_rdata = DATA_W'(st_q);
      ADDR_ENABLE: reg_rdata = DATA_W'(en_q);
      default:     reg_rdata = '0;
    endcase
  end

  pmi_irq_gate u_gate (
    .status(st_q),
    .enable(en_q),
    .irq   (irq)
  );

  // R8: soft reset or stop with no other activity leaves every bit in place
  assert_soft_immune_R8: assert property (@(posedge clk) disable iff (!hard_rst_n)
    ((soft_rst || stop) && !reg_wr && !op_done && !poll_valid) |=>
      (st_q == $past(st_q) && en_q == $past(en_q)));

  // R4: a host completion never touches the internal flag on its own
  assert_host_route_R4: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (op_done && !op_internal && !wr_status) |=> (st_q[ST_INTL] == $past(st_q[ST_INTL])));

  // R7: with both enables off the request stays low
  assert_irq_gating_R7: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (en_q == '0) |-> !irq);
endmodule

// File: tb/tb_phy_mgmt_irq_monitor.sv
`timescale 1ns/1ps
module tb_phy_mgmt_irq_monitor;
  logic        clk = 1'b0;
  logic        hard_rst_n;
  logic        soft_rst, stop, op_done, op_internal;
  logic        poll_valid, poll_ready, poll_method;
  logic [15:0] poll_data;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  phy_mgmt_irq_monitor #(.POLL_W(16)) dut (
    .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst(soft_rst), .stop(stop),
    .op_done(op_done), .op_internal(op_internal),
    .poll_valid(poll_valid), .poll_ready(poll_ready), .poll_data(poll_data),
    .poll_method(poll_method), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        pv;
    logic [15:0] pd;
    logic        pm;
    logic        od;
    logic        oi;
    logic        wr;
    logic [1:0]  ad;
    logic [7:0]  wd;
    logic [7:0]  er;
    logic        ei;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h1111, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 1'b0}, // R2 first after reset
    '{1'b1, 16'h1111, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 1'b0}, // R3 equal
    '{1'b1, 16'h2222, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h01, 1'b0}, // R1 differs
    '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 8'h03, 8'h03, 1'b1}, // R7 enable
    '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 8'h00, 8'h01, 1'b1}, // R5 write 0
    '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 8'h01, 8'h00, 1'b0}, // R5 write 1
    '{1'b1, 16'h3333, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 1'b0}, // R2 switch+poll
    '{1'b1, 16'h4444, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h01, 1'b1}, // R1 after switch
    '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 8'h01, 8'h00, 1'b0}, // R5 clear
    '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 1'b0}, // R2 lone switch
    '{1'b1, 16'h5555, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 1'b0}, // R2 suppressed
    '{1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00, 8'h02, 1'b1}, // R4 host
    '{1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 8'h02, 8'h04, 1'b1}, // R4 internal, R5
    '{1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 8'h04, 8'h04, 1'b1}, // R6 set wins
    '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 8'h01, 8'h01, 1'b0}, // R7 done gated
    '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h04, 1'b0}, // R9 readback
    '{1'b1, 16'h5555, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h04, 1'b0}  // R3 shadow kept
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    poll_valid = 1'b0; poll_data = '0; op_done = 1'b0; op_internal = 1'b0;
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic cyc();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    hard_rst_n = 1'b0; soft_rst = 1'b0; stop = 1'b0; poll_method = 1'b0;
    reg_addr = 2'd0;
    idle();
    repeat (3) @(negedge clk);
    check8("R8 reset status", reg_rdata, 8'h00);
    check8("R8 reset irq", {7'd0, irq}, 8'h00);
    reg_addr = 2'd1;
    #1 check8("R8 reset enable", reg_rdata, 8'h00);
    check8("R9 poll_ready", {7'd0, poll_ready}, 8'h01);
    hard_rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      poll_valid = VEC[i].pv; poll_data = VEC[i].pd; poll_method = VEC[i].pm;
      op_done = VEC[i].od; op_internal = VEC[i].oi; reg_wr = VEC[i].wr;
      reg_addr = VEC[i].ad; reg_wdata = VEC[i].wd;
      @(negedge clk);
      check8($sformatf("vector %0d rdata", i), reg_rdata, VEC[i].er);
      check8($sformatf("vector %0d irq R7", i), {7'd0, irq}, {7'd0, VEC[i].ei});
    end
    idle();

    // R9: unmapped address reads zero
    reg_addr = 2'd3;
    #1 check8("R9 unmapped read", reg_rdata, 8'h00);

    // R8: soft reset and stop leave status and enables intact
    reg_addr = 2'd0; soft_rst = 1'b1; stop = 1'b1;
    repeat (3) @(negedge clk);
    check8("R8 soft/stop status", reg_rdata, 8'h04);
    reg_addr = 2'd1;
    #1 check8("R8 soft/stop enable", reg_rdata, 8'h01);
    soft_rst = 1'b0; stop = 1'b0;

    // R7: internal flag reaches irq through done enable
    reg_wr = 1'b1; reg_wdata = 8'h02;
    cyc();
    idle();
    check8("R7 internal gated by done enable", {7'd0, irq}, 8'h01);

    // R8: hard reset clears everything
    @(negedge clk);
    hard_rst_n = 1'b0;
    #1;
    check8("R8 hard reset enable", reg_rdata, 8'h00);
    reg_addr = 2'd0;
    #1 check8("R8 hard reset status", reg_rdata, 8'h00);
    check8("R8 hard reset irq", {7'd0, irq}, 8'h00);
    @(negedge clk);
    hard_rst_n = 1'b1;
    @(negedge clk);

    // R2: first poll after hard reset is only loaded; R1: next differing one sets
    poll_valid = 1'b1; poll_data = 16'h9999;
    @(negedge clk);
    check8("R2 first after hard reset", reg_rdata, 8'h00);
    poll_data = 16'hAAAA;
    @(negedge clk);
    check8("R1 change after reload", reg_rdata, 8'h01);
    idle();

    // R6: set on an already set bit keeps it set
    poll_valid = 1'b1; poll_data = 16'hBBBB;
    @(negedge clk);
    check8("R6 repeated event", reg_rdata, 8'h01);
    idle();
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule